// File: doc/BRIEF.md
# Dual-Buffer Ethernet Transmit Controller

This block is the transmit half of a small memory-mapped Ethernet MAC. Software reaches it through a 32-bit word register bus. It holds two frame buffers, and each buffer has its own length word and command word. A single global interrupt enable word gates all completion interrupts. To use a buffer, software fills its data words, writes the frame length, and then writes a command. The command either streams the frame out as bytes on a valid/ready interface or copies the first six buffer bytes into the station address output.

Only one operation runs at a time. A command issued on one buffer while the other is busy waits and runs as soon as the current one finishes. A command's busy bits stay set until it completes, so software can poll. On completion the busy bits clear, and the block emits a one-cycle interrupt if both enables allow it. The block has no PHY signalling, preamble, FCS or receive path.

Top module: `etx_dual_tx`

## Requirements
- R1: After reset, every length, command and global-enable word reads 0, `tx_valid_o` and `irq_o` are 0, and `mac_o` equals the `MAC_RESET` parameter.
- R2: `bus_addr_i` is a word address over an 8 KB window, and `bus_rdata_o` returns the addressed word on the cycle after `bus_rd_i`. In each 2 KB half (half 0 at word 0, half 1 at word 512), words 0..508 are buffer storage, word 509 is the length (bits 10:0 kept, the rest read 0), and word 511 is the command. Word 510 of half 0 is the global enable, with all 32 bits kept. Word 510 of half 1 and the whole upper 4 KB read 0 and ignore writes.
- R3: A command write with bit 0 = 1 and bit 1 = 0 sends the buffer's frame. The frame has as many bytes as the length word, taken lowest word first and bits 7:0 of each word first. `tx_last_o` is high on the final byte only.
- R4: While `tx_valid_o` is high and `tx_ready_i` is low, the next cycle still has `tx_valid_o` high and the same `tx_data_o`.
- R5: A command write with bits 0 and 1 both set loads the station address from the buffer's first six bytes, with byte k in `mac_o[8k+7:8k]`. No byte is sent.
- R6: Bits 0 and 1 of a command word read back as set from the command write until the operation completes. They then read 0, and every other written bit keeps its value.
- R7: A send with length 0 completes without emitting a byte. A length above 2036 is sent as 2036 bytes.
- R8: A command on one buffer issued while the other is active waits. It runs right after the active operation completes, and the bytes of the two frames do not interleave. When both are pending, buffer 0 is served first.
- R9: On each completion, `irq_o` is high for exactly one cycle, in the first cycle the busy bits read 0. This happens only if command bit 3 of that buffer and bit 31 of the global enable word are both set.
- R10: Writes to a command word whose bit 0 reads 1 are ignored. A command write with bit 0 = 0 starts nothing and stores the value with bits 1:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the strobe |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | Downstream accepts the byte |
| mac_o | output | 48 | Station address, byte 0 in bits 7:0 |
| irq_o | output | 1 | One-cycle completion interrupt |

## Verification
The assertions check several properties on every cycle. Stream data is held while stalled. The stream drops valid after its last byte is accepted. A zero-length send never raises valid. The address-load bit is never set without the start bit. An interrupt is never raised while the global enable was clear. Busy bits clear after completion. A streaming byte always belongs to a command whose start bit is still set. Other behaviours can only be shown by the bench scenarios: byte order and frame contents, the address taken from the buffer, length clamping, queueing of a second command behind the first, ignored command writes, and the exact count of interrupt pulses against the two enables.

// File: rtl/etx_pkg.sv
// Package: shared bit positions of the command and global enable words.
// Assumes a 32-bit register bus.
package etx_pkg;
    localparam int CTRL_GO  = 0;   // start / busy bit
    localparam int CTRL_MAC = 1;   // address-load select
    localparam int CTRL_IE  = 3;   // per-buffer interrupt enable
    localparam int GIE_ON   = 31;  // global interrupt enable

    // Command handed from the arbiter to the engine.
    typedef struct packed {
        logic launch;
        logic sel;
        logic load_mac;
    } etx_cmd_t;
endpackage

// File: rtl/etx_regs.sv
// Register file and buffer storage. Decodes the word bus, holds both buffers,
// length, command and global enable words, the station address and the
// interrupt register. Assumes done_i pulses at most once per operation and
// never for a buffer whose start bit is clear.
module etx_regs #(
    parameter int          ADDR_W    = 11,
    parameter int          HALF_W    = ADDR_W - 2,
    parameter int          LEN_W     = HALF_W + 2,
    parameter logic [47:0] MAC_RESET = 48'h0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr_i,
    input  logic                   bus_rd_i,
    input  logic [ADDR_W-1:0]      bus_addr_i,
    input  logic [31:0]            bus_wdata_i,
    output logic [31:0]            bus_rdata_o,
    output logic [1:0]             go_o,
    output logic [1:0]             mac_cmd_o,
    output logic [1:0][LEN_W-1:0]  len_o,
    input  logic [HALF_W:0]        rd_addr_i,
    output logic [31:0]            rd_word_o,
    input  logic                   done_i,
    input  logic                   done_buf_i,
    input  logic                   mac_load_i,
    output logic                   irq_o,
    output logic [47:0]            mac_o
);
    import etx_pkg::*;

    localparam int HALF_WORDS = 1 << HALF_W;
    localparam int DATA_WORDS = HALF_WORDS - 3;
    localparam logic [HALF_W-1:0] LEN_OFF  = HALF_W'(HALF_WORDS - 3);
    localparam logic [HALF_W-1:0] GIE_OFF  = HALF_W'(HALF_WORDS - 2);
    localparam logic [HALF_W-1:0] CTRL_OFF = HALF_W'(HALF_WORDS - 1);

    logic [31:0]           mem [2*HALF_WORDS];
    logic [1:0][31:0]      ctrl_q;
    logic [1:0][LEN_W-1:0] len_q;
    logic [31:0]           gie_q;
    logic [31:0]           rd_mux;
    logic [47:0]           mac_q;
    logic                  irq_q;

    logic              upper, half, tx_wr, is_data;
    logic [HALF_W-1:0] off;

    // Split the word address into window half and offset.
    always_comb begin
        upper   = bus_addr_i[ADDR_W-1];
        half    = bus_addr_i[ADDR_W-2];
        off     = bus_addr_i[HALF_W-1:0];
        tx_wr   = bus_wr_i && !upper;
        is_data = int'(off) < DATA_WORDS;
    end

    // Buffer storage write port (no reset on storage).
    always_ff @(posedge clk) begin
        if (tx_wr && is_data) mem[{half, off}] <= bus_wdata_i;
    end

    // Length, command and global enable words; completion clears busy bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            len_q  <= '0;
            gie_q  <= '0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (done_i && done_buf_i == b[0]) ctrl_q[b][CTRL_MAC:CTRL_GO] <= 2'b00;
            end
            if (tx_wr && off == CTRL_OFF && !ctrl_q[half][CTRL_GO]) begin
                ctrl_q[half] <= bus_wdata_i;
                if (!bus_wdata_i[CTRL_GO]) ctrl_q[half][CTRL_MAC] <= 1'b0;
            end
            if (tx_wr && off == LEN_OFF) len_q[half] <= bus_wdata_i[LEN_W-1:0];
            if (tx_wr && off == GIE_OFF && !half) gie_q <= bus_wdata_i;
        end
    end

    // Read multiplexer for the bus.
    always_comb begin
        rd_mux = '0;
        if (!upper) begin
            if (is_data)                  rd_mux = mem[{half, off}];
            else if (off == LEN_OFF)      rd_mux = 32'(len_q[half]);
            else if (off == GIE_OFF)      rd_mux = half ? 32'h0 : gie_q;
            else                          rd_mux = ctrl_q[half];
        end
    end

    // Registered read data, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_rdata_o <= '0;
        else if (bus_rd_i) bus_rdata_o <= rd_mux;
    end

    // Station address load and gated interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mac_q <= MAC_RESET;
            irq_q <= 1'b0;
        end else begin
            if (mac_load_i)
                mac_q <= {mem[{done_buf_i, HALF_W'(1)}][15:0], mem[{done_buf_i, HALF_W'(0)}]};
            irq_q <= done_i && ctrl_q[done_buf_i][CTRL_IE] && gie_q[GIE_ON];
        end
    end

    assign rd_word_o = mem[rd_addr_i];
    assign mac_o     = mac_q;
    assign irq_o     = irq_q;
    assign go_o      = {ctrl_q[1][CTRL_GO], ctrl_q[0][CTRL_GO]};
    assign mac_cmd_o = {ctrl_q[1][CTRL_MAC], ctrl_q[0][CTRL_MAC]};
    assign len_o     = len_q;

    // R10: address-load bit never stands without the start bit
    p_mac_needs_go0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[0][CTRL_MAC] |-> ctrl_q[0][CTRL_GO]);
    p_mac_needs_go1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[1][CTRL_MAC] |-> ctrl_q[1][CTRL_GO]);
    // R9: an interrupt needs the global enable in the completing cycle
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(gie_q[GIE_ON]));
    // R6: completion leaves the busy bit clear
    p_done_clears0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && !done_buf_i |=> !ctrl_q[0][CTRL_GO]);
    p_done_clears1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && done_buf_i |=> !ctrl_q[1][CTRL_GO]);
endmodule

// File: rtl/etx_arbiter.sv
// Picks the next pending command when the engine is idle. Buffer 0 has
// priority. Clamps the length to the buffer's data area. Purely combinational.
module etx_arbiter #(
    parameter int LEN_W      = 11,
    parameter int DATA_BYTES = 2036
) (
    input  logic [1:0]            go_i,
    input  logic [1:0]            mac_i,
    input  logic [1:0][LEN_W-1:0] len_i,
    input  logic                  busy_i,
    output etx_pkg::etx_cmd_t     cmd_o,
    output logic [LEN_W-1:0]      len_o
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(DATA_BYTES);

    logic [LEN_W-1:0] raw_len;

    // Fixed priority selection and length clamp.
    always_comb begin
        cmd_o.sel      = !go_i[0];
        cmd_o.launch   = (|go_i) && !busy_i;
        cmd_o.load_mac = mac_i[cmd_o.sel];
        raw_len        = len_i[cmd_o.sel];
        len_o          = (raw_len > MAX_LEN) ? MAX_LEN : raw_len;
    end
endmodule

// File: rtl/etx_engine.sv
// Executes one command at a time. A send streams bytes from the selected
// buffer, low byte of each word first. An address load or a zero-length
// send completes in its launch cycle. Assumes launch only arrives when idle.
module etx_engine #(
    parameter int LEN_W  = 11,
    parameter int HALF_W = LEN_W - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  etx_pkg::etx_cmd_t     cmd_i,
    input  logic [LEN_W-1:0]      len_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  done_buf_o,
    output logic                  mac_load_o,
    output logic [HALF_W:0]       rd_addr_o,
    input  logic [31:0]           rd_word_i,
    output logic [7:0]            tx_data_o,
    output logic                  tx_valid_o,
    output logic                  tx_last_o,
    input  logic                  tx_ready_i
);
    logic             busy_q, buf_q;
    logic [LEN_W-1:0] idx_q, last_q;
    logic             fire, fin, at_last, quick;

    // Handshake and completion decode.
    always_comb begin
        at_last = idx_q == last_q;
        fire    = busy_q && tx_ready_i;
        fin     = fire && at_last;
        quick   = cmd_i.launch && (cmd_i.load_mac || len_i == '0);
    end

    // Stream state: start on launch, step per accepted byte, stop after last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            buf_q  <= 1'b0;
            idx_q  <= '0;
            last_q <= '0;
        end else if (cmd_i.launch && !quick) begin
            busy_q <= 1'b1;
            buf_q  <= cmd_i.sel;
            idx_q  <= '0;
            last_q <= len_i - 1'b1;
        end else if (fin) begin
            busy_q <= 1'b0;
        end else if (fire) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign busy_o     = busy_q;
    assign done_o     = fin || quick;
    assign done_buf_o = busy_q ? buf_q : cmd_i.sel;
    assign mac_load_o = cmd_i.launch && cmd_i.load_mac;
    assign rd_addr_o  = {buf_q, idx_q[LEN_W-1:2]};
    assign tx_data_o  = rd_word_i[8*idx_q[1:0] +: 8];
    assign tx_valid_o = busy_q;
    assign tx_last_o  = busy_q && at_last;

    // R4: a stalled byte stays valid and unchanged
    p_hold_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));
    // R3: accepting the last byte ends the frame
    p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && tx_ready_i && tx_last_o |=> !tx_valid_o);
    // R7: a zero-length send never raises valid
    p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.launch && !cmd_i.load_mac && len_i == '0 |=> !tx_valid_o);
endmodule

// File: rtl/etx_dual_tx.sv
// Top: dual-buffer transmit controller. Joins the register file, the
// arbiter and the streaming engine. Assumes word-only bus access.
module etx_dual_tx #(
    parameter int          ADDR_W    = 11,
    parameter logic [47:0] MAC_RESET = 48'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic [7:0]        tx_data_o,
    output logic              tx_valid_o,
    output logic              tx_last_o,
    input  logic              tx_ready_i,
    output logic [47:0]       mac_o,
    output logic              irq_o
);
    localparam int HALF_W     = ADDR_W - 2;
    localparam int LEN_W      = HALF_W + 2;
    localparam int DATA_BYTES = 4 * ((1 << HALF_W) - 3);

    logic [1:0]            go, mac_cmd;
    logic [1:0][LEN_W-1:0] len_w;
    logic [LEN_W-1:0]      eff_len;
    logic [HALF_W:0]       rd_addr;
    logic [31:0]           rd_word;
    logic                  busy, done, done_buf, mac_load;
    etx_pkg::etx_cmd_t     cmd;

    etx_regs #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .LEN_W(LEN_W), .MAC_RESET(MAC_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .go_o(go), .mac_cmd_o(mac_cmd), .len_o(len_w),
        .rd_addr_i(rd_addr), .rd_word_o(rd_word),
        .done_i(done), .done_buf_i(done_buf), .mac_load_i(mac_load),
        .irq_o(irq_o), .mac_o(mac_o)
    );

    etx_arbiter #(.LEN_W(LEN_W), .DATA_BYTES(DATA_BYTES)) u_arb (
        .go_i(go), .mac_i(mac_cmd), .len_i(len_w), .busy_i(busy),
        .cmd_o(cmd), .len_o(eff_len)
    );

    etx_engine #(.LEN_W(LEN_W), .HALF_W(HALF_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .len_i(eff_len),
        .busy_o(busy), .done_o(done), .done_buf_o(done_buf), .mac_load_o(mac_load),
        .rd_addr_o(rd_addr), .rd_word_i(rd_word),
        .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_last_o(tx_last_o),
        .tx_ready_i(tx_ready_i)
    );

    // R6: a streaming byte belongs to a command whose start bit is still set
    p_stream_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> |go);
    // R8: a new command is never launched over a running one
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.launch |-> !tx_valid_o);
endmodule

// File: tb/etx_dual_tx_tb_top.sv
module etx_dual_tx_tb_top;
    localparam int ADDR_W = 11;
    localparam logic [47:0] MACR = 48'hA1B2_C3D4_E5F6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b0;
    logic [47:0] mac;
    logic        irq;

    int n_chk = 0, n_fail = 0, irq_cnt = 0;
    bit rdy_all = 1'b0;
    bit hold_pend = 1'b0;
    logic [7:0] held_data;
    logic [7:0] cap[$];
    bit         cap_last[$];
    logic [31:0] model [2][512];

    always #4 clk = ~clk;

    etx_dual_tx #(.ADDR_W(ADDR_W), .MAC_RESET(MACR)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last),
        .tx_ready_i(tx_ready), .mac_o(mac), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Stream monitor, ready driver and interrupt counter (away from the edge).
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend) chk(tx_valid && tx_data == held_data, "R4 hold", {tx_valid, tx_data}, {1'b1, held_data});
            tx_ready = rdy_all ? 1'b1 : 1'($urandom_range(0, 1));
            if (tx_valid && tx_ready) begin
                cap.push_back(tx_data);
                cap_last.push_back(tx_last);
            end
            hold_pend = tx_valid && !tx_ready;
            held_data = tx_data;
            if (irq) irq_cnt++;
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = ADDR_W'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic fill(input int b, input int words);
        for (int w = 0; w < words; w++) begin
            model[b][w] = $urandom;
            wr(b*512 + w, model[b][w]);
        end
    endtask

    function automatic logic [7:0] mbyte(input int b, input int i);
        return model[b][i >> 2][8*(i & 3) +: 8];
    endfunction

    task automatic wait_done(input int b);
        logic [31:0] v;
        int n = 0;
        do begin
            rd(b*512 + 511, v);
            n++;
        end while (v[0] && n < 6000);
        repeat (2) @(negedge clk);
    endtask

    // Checks the captured stream from position st against buffer b.
    task automatic chk_frame(input int b, input int len, input int st, input string req);
        bit ok = 1'b1;
        int bad = 0;
        for (int i = 0; i < len; i++) begin
            if (st + i >= cap.size() || cap[st+i] !== mbyte(b, i) || cap_last[st+i] != (i == len-1)) begin
                if (ok) bad = i;
                ok = 1'b0;
            end
        end
        chk(ok, req, 64'(bad), 64'(len));
    endtask

    initial begin
        logic [31:0] v;
        int len0, len1;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(tx_valid == 1'b0 && irq == 1'b0, "R1 outputs", {tx_valid, irq}, 0);
        chk(mac == MACR, "R1 mac", mac, MACR);
        rd(509, v); chk(v == 0, "R1 len0", v, 0);
        rd(511, v); chk(v == 0, "R1 ctrl0", v, 0);
        rd(510, v); chk(v == 0, "R1 gie", v, 0);
        rd(1023, v); chk(v == 0, "R1 ctrl1", v, 0);

        // R2: register map
        wr(5, 32'hDEAD_BEEF); rd(5, v); chk(v == 32'hDEAD_BEEF, "R2 data", v, 32'hDEAD_BEEF);
        wr(509, 32'hFFFF_FFFF); rd(509, v); chk(v == 32'h7FF, "R2 len mask", v, 32'h7FF);
        wr(510, 32'h8000_0001); rd(510, v); chk(v == 32'h8000_0001, "R2 gie", v, 32'h8000_0001);
        wr(1022, 32'h1234_5678); rd(1022, v); chk(v == 0, "R2 half1 gie slot", v, 0);
        wr(1024 + 3, 32'h5555_AAAA); rd(1024 + 3, v); chk(v == 0, "R2 upper half", v, 0);

        // R3, R6, R9: send from buffer 0 with both enables
        len0 = 37; fill(0, 10);
        wr(509, len0); wr(510, 32'h8000_0000);
        cap.delete(); cap_last.delete(); irq_cnt = 0;
        wr(511, 32'h0000_0109);
        rd(511, v); chk(v[1:0] == 2'b01, "R6 busy bits", v, 32'h109);
        wait_done(0);
        chk_frame(0, len0, 0, "R3 frame bytes");
        chk(cap.size() == len0, "R3 count", cap.size(), len0);
        rd(511, v); chk(v == 32'h108, "R6 cleared keep others", v, 32'h108);
        chk(irq_cnt == 1, "R9 one pulse", irq_cnt, 1);

        // R5, R9: address load from buffer 1, interrupt disabled per buffer
        fill(1, 2);
        cap.delete(); cap_last.delete(); irq_cnt = 0;
        wr(1023, 32'h3);
        wait_done(1);
        chk(mac == {model[1][1][15:0], model[1][0]}, "R5 mac", mac, {model[1][1][15:0], model[1][0]});
        chk(cap.size() == 0, "R5 no bytes", cap.size(), 0);
        chk(irq_cnt == 0, "R9 masked by buffer bit", irq_cnt, 0);

        // R7: zero length
        wr(509, 0); cap.delete(); cap_last.delete();
        wr(511, 32'h1); wait_done(0);
        chk(cap.size() == 0, "R7 zero length", cap.size(), 0);

        // R8, R10: queued second buffer, ignored command write while busy
        len0 = 20; len1 = 15; fill(0, 5); fill(1, 4);
        wr(509, len0); wr(1021, len1);
        cap.delete(); cap_last.delete(); irq_cnt = 0;
        wr(511, 32'h9);
        wr(1023, 32'h9);
        rd(1023, v); chk(v[0] == 1'b1, "R8 pending", v, 32'h9);
        wr(511, 32'h2);
        wait_done(0); wait_done(1);
        chk_frame(0, len0, 0, "R8 first frame");
        chk_frame(1, len1, len0, "R8 second frame");
        chk(cap.size() == len0 + len1, "R8 total", cap.size(), len0 + len1);
        rd(511, v); chk(v == 32'h8, "R10 ignored while busy", v, 32'h8);
        chk(irq_cnt == 2, "R9 two pulses", irq_cnt, 2);

        // R10: bit 0 clear starts nothing
        cap.delete(); cap_last.delete(); irq_cnt = 0;
        wr(1023, 32'hA);
        repeat (6) @(negedge clk);
        rd(1023, v); chk(v == 32'h8, "R10 no start", v, 32'h8);
        chk(cap.size() == 0 && irq_cnt == 0, "R10 no activity", {cap.size(), irq_cnt}, 0);

        // R7: clamp of an oversize length
        rdy_all = 1'b1;
        fill(0, 509);
        wr(509, 32'h7FF); cap.delete(); cap_last.delete();
        wr(511, 32'h1); wait_done(0);
        chk(cap.size() == 2036, "R7 clamp", cap.size(), 2036);
        chk_frame(0, 2036, 0, "R7 clamp bytes");
        rdy_all = 1'b0;

        // Random mix of sends and address loads
        for (int it = 0; it < 16; it++) begin
            int b, ln; bit ie, ge, ld;
            logic [47:0] mexp;
            b = $urandom_range(0, 1); ln = $urandom_range(0, 48);
            ie = 1'($urandom_range(0, 1)); ge = 1'($urandom_range(0, 1));
            ld = ($urandom_range(0, 3) == 0);
            fill(b, (ln + 3) / 4 + 2);
            wr(b*512 + 509, ln); wr(510, {ge, 31'h0});
            cap.delete(); cap_last.delete(); irq_cnt = 0;
            mexp = ld ? {model[b][1][15:0], model[b][0]} : mac;
            wr(b*512 + 511, {28'h0, ie, 1'b0, ld, 1'b1});
            wait_done(b);
            if (ld) begin
                chk(mac == mexp && cap.size() == 0, "R5 random load", mac, mexp);
            end else begin
                chk(cap.size() == ln, "R3 random count", cap.size(), ln);
                chk_frame(b, ln, 0, "R3 random bytes");
            end
            chk(irq_cnt == int'(ie && ge), "R9 random irq", irq_cnt, int'(ie && ge));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule